// File: doc/BRIEF.md
# MLT-3 Line Code Transceiver Core

This core is the digital half of a twisted-pair physical layer that runs at one symbol per 8 ns clock (125 Mbaud). On the transmit side it receives one NRZI bit per clock, in which a change of level stands for a one and an unchanged level for a zero. It turns each change into one step of a three-level walk that visits 0, +V, 0, -V and then repeats, so the line never swings straight from one rail to the other. The fundamental frequency on the line is therefore half of what NRZI would need. The line level is a 2-bit two's-complement code: 01 is +V, 00 is 0 and 11 is -V.

On the receive side a sliced three-level symbol arrives every clock. The core rebuilds NRZI by flipping its output whenever the symbol differs from the one on the previous clock. An analog front end supplies one flag that says whether the received amplitude is above threshold, and the core reports it as a complementary signal-detect pair. Two active-low controls change the data path. The first parks the transmitter: the line is held at 0 and a high-impedance indication is raised. The second loops the transmit walk back into the receive decoder: the line is kept quiet, line input is ignored, and signal detect is forced on.

Both line interfaces are continuous. One symbol moves in each direction on every clock, and neither side can push back, so the ports carry no valid or ready signals.

Top module: `mlt3_xcvr`

## Requirements
- R1: Two clocks after the edge that samples a `tx_nrzi` value different from the value sampled on the previous edge, `tx_level` differs from its value one clock earlier, provided transmit is enabled and loopback is off.
- R2: A `tx_nrzi` value equal to the previously sampled one leaves the walk where it is, so `tx_level` holds two clocks later.
- R3: After reset, successive transitions drive `tx_level` through 01, 00, 11, 00, 01 and onward. `tx_level` never goes from 01 to 11, or from 11 to 01, on consecutive clocks.
- R4: One clock after `tx_off_n` is sampled low, `tx_level` is 00 and `tx_hiz` is 1. `tx_hiz` is 0 whenever `tx_off_n` was sampled high.
- R5: With loopback active (`lpbk_n` low) and transmit enabled, `tx_level` is 00 and `tx_hiz` is 0 one clock later.
- R6: One clock after `lpbk_n` is sampled low, `sd_p` is 1 and `sd_n` is 0, whatever `rx_above_thr` says.
- R7: Outside loopback, `rx_nrzi` toggles one clock after `rx_level` differs from the value sampled on the clock before. Otherwise it holds.
- R8: Outside loopback, `sd_p` equals `rx_above_thr` one clock later and `sd_n` is its complement. A low flag reports an invalid link: `sd_p` 0, `sd_n` 1.
- R9: Synchronous active-high reset gives `tx_level` 00, `tx_hiz` 0, `rx_nrzi` 0, `sd_p` 0 and `sd_n` 1. It also returns the walk to its first phase, so the first transition afterwards produces 01.
- R10: In loopback started from reset, `rx_nrzi` reproduces the `tx_nrzi` stream delayed by two clocks, and any value on `rx_level` has no effect.
- R11: While transmit is parked the walk keeps following the data. After release, `tx_level` shows the phase the walk has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per cycle |
| rst | input | 1 | Synchronous reset, active high |
| tx_nrzi | input | 1 | Transmit NRZI bit |
| tx_off_n | input | 1 | Transmit disable, active low |
| lpbk_n | input | 1 | Internal loopback, active low |
| rx_level | input | 2 | Sliced received level (01 +V, 00 zero, 11 -V) |
| rx_above_thr | input | 1 | Received amplitude above threshold |
| tx_level | output | 2 | Line level to driver (01 +V, 00 zero, 11 -V) |
| tx_hiz | output | 1 | Driver high-impedance indication |
| rx_nrzi | output | 1 | Recovered NRZI bit |
| sd_p | output | 1 | Signal detect, true rail |
| sd_n | output | 1 | Signal detect, complement rail |

## Verification
The hardest state to reach is a parked transmitter whose walk has moved on while the line shows nothing. That position only becomes visible at the ports when transmit is released. The stimulus parks the driver in the middle of a pseudo-random stream that has many transitions, releases it, and compares the level that comes back with a reference walk kept in the bench. Loopback is exercised in the same way: noisy line input is applied while `rx_nrzi` is checked against the transmit bits from two clocks earlier.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;
  localparam int LVL_W = 2;
  localparam int PH_W  = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [PH_W-1:0]  phase_t;

  localparam lvl_t LVL_ZERO = 2'b00;
  localparam lvl_t LVL_POS  = 2'b01;
  localparam lvl_t LVL_NEG  = 2'b11;

  // Walk phases: even phases sit at zero, phase 1 at +V, phase 3 at -V.
  function automatic lvl_t phase_level(input phase_t ph);
    lvl_t r;
    if (!ph[0])      r = LVL_ZERO;
    else if (ph[1])  r = LVL_NEG;
    else             r = LVL_POS;
    return r;
  endfunction
endpackage

// File: rtl/mlt3_walk_enc.sv
module mlt3_walk_enc
  import mlt3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nrzi_i,
  output lvl_t lvl_o
);
  logic   prev_q;
  phase_t ph_q;
  phase_t ph_next;
  lvl_t   lvl_q;
  logic   flip;

  assign flip    = nrzi_i ^ prev_q;
  assign ph_next = ph_q + phase_t'(flip);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      ph_q   <= '0;
      lvl_q  <= LVL_ZERO;
    end else begin
      prev_q <= nrzi_i;
      ph_q   <= ph_next;
      lvl_q  <= phase_level(ph_next);
    end
  end

  assign lvl_o = lvl_q;

  // R1: a data transition moves the walk
  a_r1_flip_moves: assert property (@(posedge clk) disable iff (rst)
    flip |=> (lvl_q != $past(lvl_q)));
  // R2: no transition, no movement
  a_r2_hold_still: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(lvl_q));
endmodule

// File: rtl/mlt3_line_drv.sv
module mlt3_line_drv
  import mlt3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t lvl_i,
  input  logic tx_off_n,
  input  logic lpbk_n,
  output lvl_t line_o,
  output logic hiz_o
);
  lvl_t line_q;
  logic hiz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= LVL_ZERO;
      hiz_q  <= 1'b0;
    end else begin
      line_q <= (tx_off_n && lpbk_n) ? lvl_i : LVL_ZERO;
      hiz_q  <= !tx_off_n;
    end
  end

  assign line_o = line_q;
  assign hiz_o  = hiz_q;

  // R4: parked driver
  a_r4_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_off_n |=> (line_q == LVL_ZERO && hiz_q));
  // R5: loopback keeps the line at zero, still driven
  a_r5_loop_line_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_off_n && !lpbk_n) |=> (line_q == LVL_ZERO && !hiz_q));
  // R3: no rail-to-rail step
  a_r3_no_pos_to_neg: assert property (@(posedge clk) disable iff (rst)
    (line_q == LVL_POS) |=> (line_q != LVL_NEG));
  a_r3_no_neg_to_pos: assert property (@(posedge clk) disable iff (rst)
    (line_q == LVL_NEG) |=> (line_q != LVL_POS));
endmodule

// File: rtl/mlt3_walk_dec.sv
module mlt3_walk_dec
  import mlt3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t sym_i,
  output logic nrzi_o
);
  lvl_t prev_q;
  logic nrzi_q;
  logic moved;

  assign moved = (sym_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LVL_ZERO;
      nrzi_q <= 1'b0;
    end else begin
      prev_q <= sym_i;
      nrzi_q <= nrzi_q ^ moved;
    end
  end

  assign nrzi_o = nrzi_q;

  // R7: level change toggles the recovered bit, otherwise it holds
  a_r7_toggle_on_move: assert property (@(posedge clk) disable iff (rst)
    moved |=> (nrzi_q != $past(nrzi_q)));
  a_r7_hold_on_rest: assert property (@(posedge clk) disable iff (rst)
    !moved |=> $stable(nrzi_q));
endmodule

// File: rtl/mlt3_sig_det.sv
module mlt3_sig_det (
  input  logic clk,
  input  logic rst,
  input  logic above_i,
  input  logic lpbk_n,
  output logic sd_p,
  output logic sd_n
);
  logic sd_q;

  always_ff @(posedge clk) begin
    if (rst) sd_q <= 1'b0;
    else     sd_q <= !lpbk_n || above_i;
  end

  assign sd_p = sd_q;
  assign sd_n = ~sd_q;

  // R6: loopback forces detect
  a_r6_loop_forces_sd: assert property (@(posedge clk) disable iff (rst)
    !lpbk_n |=> (sd_p && !sd_n));
  // R8: weak signal reports invalid link
  a_r8_weak_drops_sd: assert property (@(posedge clk) disable iff (rst)
    (lpbk_n && !above_i) |=> (!sd_p && sd_n));
endmodule

// File: rtl/mlt3_xcvr.sv
module mlt3_xcvr
  import mlt3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_nrzi,
  input  logic             tx_off_n,
  input  logic             lpbk_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_above_thr,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_hiz,
  output logic             rx_nrzi,
  output logic             sd_p,
  output logic             sd_n
);
  lvl_t enc_lvl;
  lvl_t dec_src;
  lvl_t line_lvl;

  mlt3_walk_enc u_enc (
    .clk    (clk),
    .rst    (rst),
    .nrzi_i (tx_nrzi),
    .lvl_o  (enc_lvl)
  );

  mlt3_line_drv u_drv (
    .clk      (clk),
    .rst      (rst),
    .lvl_i    (enc_lvl),
    .tx_off_n (tx_off_n),
    .lpbk_n   (lpbk_n),
    .line_o   (line_lvl),
    .hiz_o    (tx_hiz)
  );

  // Loopback mux: internal walk replaces the sliced line symbol.
  assign dec_src = lpbk_n ? lvl_t'(rx_level) : enc_lvl;

  mlt3_walk_dec u_dec (
    .clk    (clk),
    .rst    (rst),
    .sym_i  (dec_src),
    .nrzi_o (rx_nrzi)
  );

  mlt3_sig_det u_sd (
    .clk     (clk),
    .rst     (rst),
    .above_i (rx_above_thr),
    .lpbk_n  (lpbk_n),
    .sd_p    (sd_p),
    .sd_n    (sd_n)
  );

  assign tx_level = line_lvl;
endmodule

// File: tb/test_mlt3_xcvr.sv
`timescale 1ns/1ps
module test_mlt3_xcvr;
  import mlt3_pkg::*;

  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_nrzi = 1'b0;
  logic       tx_off_n = 1'b1;
  logic       lpbk_n = 1'b1;
  logic [1:0] rx_level = 2'b00;
  logic       rx_above_thr = 1'b0;
  logic [1:0] tx_level;
  logic       tx_hiz;
  logic       rx_nrzi;
  logic       sd_p;
  logic       sd_n;

  mlt3_xcvr i_mlt3_xcvr (
    .clk(clk), .rst(rst), .tx_nrzi(tx_nrzi), .tx_off_n(tx_off_n),
    .lpbk_n(lpbk_n), .rx_level(rx_level), .rx_above_thr(rx_above_thr),
    .tx_level(tx_level), .tx_hiz(tx_hiz), .rx_nrzi(rx_nrzi),
    .sd_p(sd_p), .sd_n(sd_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         due;
    int         kind;
    logic [1:0] val;
    string      req;
  } item_t;
  item_t sb[$];

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  // Monitor: compare every item that falls due on this cycle.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        case (sb[i].kind)
          0: chk(sb[i].req, "tx_level", tx_level, sb[i].val);
          1: chk(sb[i].req, "tx_hiz", {1'b0, tx_hiz}, sb[i].val);
          2: chk(sb[i].req, "rx_nrzi", {1'b0, rx_nrzi}, sb[i].val);
          3: chk(sb[i].req, "sd_p", {1'b0, sd_p}, sb[i].val);
          default: chk(sb[i].req, "sd_n", {1'b0, sd_n}, sb[i].val);
        endcase
        sb.delete(i);
      end
    end
  end

  // Reference state, built from the requirements
  logic       m_prev, m_rx;
  logic [1:0] m_phase, m_enc, m_dprev;
  logic [10:0] lfsr = 11'h5A3;

  function automatic logic [1:0] walk_lvl(input logic [1:0] ph);
    case (ph)
      2'd1:    return 2'b01;
      2'd3:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic next_rand();
    logic b;
    b = lfsr[10] ^ lfsr[8];
    lfsr = {lfsr[9:0], b};
    return b;
  endfunction

  function automatic logic [1:0] rand_lvl();
    logic a, b;
    a = next_rand();
    b = next_rand();
    if (!a)     return 2'b00;
    else if (b) return 2'b11;
    else        return 2'b01;
  endfunction

  task automatic push(input int kind, input logic [1:0] v, input string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(input logic b, input logic off_n, input logic lp_n,
                      input logic [1:0] rxl, input logic amp, input string req_tx);
    logic [1:0] line_e, src;
    logic       sd_e;
    string      tag;
    tx_nrzi = b; tx_off_n = off_n; lpbk_n = lp_n;
    rx_level = rxl; rx_above_thr = amp;
    line_e = (off_n && lp_n) ? m_enc : 2'b00;
    src    = lp_n ? rxl : m_enc;
    if (src != m_dprev) m_rx = ~m_rx;
    m_dprev = src;
    sd_e = !lp_n || amp;
    if (b != m_prev) m_phase = m_phase + 2'd1;
    m_prev = b;
    m_enc  = walk_lvl(m_phase);
    tag = !off_n ? "R4" : (!lp_n ? "R5" : req_tx);
    push(0, line_e, tag);
    push(1, {1'b0, !off_n}, tag);
    push(2, {1'b0, m_rx}, lp_n ? "R7" : "R10");
    push(3, {1'b0, sd_e}, lp_n ? "R8" : "R6");
    push(4, {1'b0, !sd_e}, lp_n ? "R8" : "R6");
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_nrzi = 1'b0; tx_off_n = 1'b1; lpbk_n = 1'b1;
    rx_level = 2'b00; rx_above_thr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", "tx_level", tx_level, 2'b00);
    chk("R9", "tx_hiz", {1'b0, tx_hiz}, 2'b00);
    chk("R9", "rx_nrzi", {1'b0, rx_nrzi}, 2'b00);
    chk("R9", "sd_p", {1'b0, sd_p}, 2'b00);
    chk("R9", "sd_n", {1'b0, sd_n}, 2'b01);
    rst = 1'b0;
    m_prev = 1'b0; m_rx = 1'b0; m_phase = 2'd0; m_enc = 2'b00; m_dprev = 2'b00;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic d;
    do_reset();

    // R3: every bit a transition, walk 01,00,11,00,... (R9 first step to 01)
    for (int i = 0; i < 8; i++) step(~m_prev, 1, 1, 2'b00, 1, "R3");
    // R2: held data, walk must not move
    for (int i = 0; i < 6; i++) step(m_prev, 1, 1, 2'b00, 1, "R2");

    // R1: scrambled stream through NRZI, random line input
    d = m_prev;
    for (int i = 0; i < 150; i++) begin
      d = d ^ next_rand();
      step(d, 1, 1, rand_lvl(), 1, "R1");
    end

    // R4: park transmit while data keeps changing
    for (int i = 0; i < 20; i++) begin
      d = d ^ next_rand();
      step(d, 0, 1, rand_lvl(), 1, "R4");
    end
    // R11: release, walk resumes where the data took it
    for (int i = 0; i < 20; i++) begin
      d = d ^ next_rand();
      step(d, 1, 1, rand_lvl(), 1, "R11");
    end

    // R8: amplitude flag toggling
    for (int i = 0; i < 30; i++) begin
      d = d ^ next_rand();
      step(d, 1, 1, rand_lvl(), (i % 5) < 2, "R1");
    end

    // R10 / R5 / R6: loopback from reset with noisy line input, weak signal
    do_reset();
    d = 1'b0;
    for (int i = 0; i < 100; i++) begin
      d = d ^ next_rand();
      step(d, 1, 0, rand_lvl(), 0, "R5");
    end
    // loopback combined with park
    for (int i = 0; i < 10; i++) begin
      d = d ^ next_rand();
      step(d, 0, 0, rand_lvl(), 0, "R4");
    end
    // back to normal operation
    for (int i = 0; i < 20; i++) begin
      d = d ^ next_rand();
      step(d, 1, 1, rand_lvl(), 1, "R11");
    end

    step(d, 1, 1, 2'b00, 1, "R2");
    @(negedge clk);
    finish_run();
  end
endmodule